// File: doc/BRIEF.md
# Performance-Monitor User Access Gate

This block sits between a core's special-register access port and a small set of performance-monitor registers. The set has three control registers (a main control word, a per-counter freeze word and an auxiliary control word) and six event counters. The main control word holds a two-bit user-access mode field. Every unprivileged access is checked against that field. The block then either performs the access or reports an exception with a cause code. Privileged accesses are never checked.

Granted user accesses see only some fields of the two main control words. A user read returns only the permitted bits, with all other bits as zero. A user write merges the permitted bits into the stored value and leaves the other bits as they were. User register numbers lie 0x10 below the privileged numbers of the same registers. Counting, interrupt delivery and instruction decode belong to neighbouring logic.

A request is accepted in one cycle, and its response (read data or exception) appears on the next cycle. Register writes take effect at the edge on which the request is sampled.

Top module: `pmu_user_gate`

## Requirements
- R1: After reset every register reads zero and the mode field (main control bits 11:10) is 00, so user reads are granted and user writes are refused.
- R2: Privileged accesses read and write the full 64-bit register and never raise an exception.
- R3: User reads are granted in modes 00, 10 and 11. In mode 01 a user read raises an exception with cause 0 (facility unavailable).
- R4: User writes are granted only in modes 10 and 11. Mode 00 raises cause 1 (emulation assist) and mode 01 raises cause 0. A refused access returns zero data and changes no register.
- R5: In mode 11, any user read or write of counters 5 and 6 raises cause 0. This check comes before the group check. Counters 1 to 4 stay accessible in mode 11.
- R6: A user read of the main control word returns only bits 31 (freeze all), 26 (alert enable) and 7 (alert pending). A user read of the freeze word returns only the bits in a parameter mask (default 0x3F).
- R7: A user write to either main control word takes the masked bits from the write data and keeps every other stored bit. The user therefore cannot change the mode field. User writes to the auxiliary word and the counters are full width.
- R8: Privileged numbers start at 0x310, in this order: main control, freeze word, auxiliary control, counters 1 to 6. A user number plus 0x10 gives the privileged number. An unmapped number returns zero, raises no exception and changes nothing.
- R9: Each request produces exactly one response-valid pulse on the next cycle. Exception-valid pulses in that same cycle only when the access is refused, and the cause code is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = unprivileged access |
| req_addr | input | 10 | Special-register number |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data, zero for writes and refused accesses |
| exc_valid | output | 1 | Access refused |
| exc_cause | output | 1 | 0 = facility unavailable, 1 = emulation assist |

## Verification
The bench walks the mode field through all four values. In each mode it issues user reads and writes to the control words, to a low counter and to counters 5 and 6. This separates the read-grant rule from the write-grant rule, and it separates the two exception causes from each other. Writes of all-ones and all-zeros over known patterns are read back with privileged reads, which shows whether masked bits were merged or overwritten and whether refused writes left the state alone. Numbers just outside both address windows, and privileged use of user numbers, show that the remap does not alias.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;
  localparam int NCNT     = 6;
  localparam int NCTL     = 3;
  localparam int NREG     = NCTL + NCNT;
  localparam int IDX_CTL0 = 0;
  localparam int IDX_FRZ  = 1;
  localparam int IDX_AUX  = 2;
  localparam int IDX_CNT1 = 3;
  localparam int IDX_CNT5 = IDX_CNT1 + 4;
  localparam int IDX_CNT6 = IDX_CNT1 + 5;

  typedef enum logic [1:0] {
    UMODE_READ  = 2'b00,
    UMODE_BLOCK = 2'b01,
    UMODE_FULL  = 2'b10,
    UMODE_FOUR  = 2'b11
  } umode_e;

  typedef enum logic {
    CAUSE_FAC = 1'b0,
    CAUSE_EMU = 1'b1
  } cause_e;
endpackage

// File: rtl/pmu_gate_addr_map.sv
module pmu_gate_addr_map #(
  parameter int AW = 10,
  parameter logic [AW-1:0] PRIV_BASE = 10'h310,
  parameter logic [AW-1:0] UREMAP = 10'h010,
  parameter int NREG = 9,
  parameter int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          user,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [AW-1:0] eff;
  logic [AW-1:0] off;

  always_comb begin
    eff = user ? (addr + UREMAP) : addr;
    off = eff - PRIV_BASE;
    hit = (off < AW'(NREG));
    idx = hit ? off[IW-1:0] : '0;
  end
endmodule

// File: rtl/pmu_gate_perm.sv
module pmu_gate_perm
  import pmu_gate_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          valid,
  input  logic          write,
  input  logic          user,
  input  logic          hit,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    mode,
  output logic          grant,
  output logic          deny,
  output cause_e        cause
);
  logic upper_cnt;

  always_comb begin
    upper_cnt = (idx == IW'(IDX_CNT5)) || (idx == IW'(IDX_CNT6));
    grant = 1'b0;
    deny  = 1'b0;
    cause = CAUSE_FAC;
    if (valid && hit) begin
      if (!user) begin
        grant = 1'b1;
      end else if (upper_cnt && (mode == UMODE_FOUR)) begin
        deny = 1'b1;
      end else if (!write) begin
        if (mode == UMODE_BLOCK) deny = 1'b1;
        else                     grant = 1'b1;
      end else if (mode[1]) begin
        grant = 1'b1;
      end else begin
        deny  = 1'b1;
        cause = (mode == UMODE_BLOCK) ? CAUSE_FAC : CAUSE_EMU;
      end
    end
  end
endmodule

// File: rtl/pmu_gate_regs.sv
module pmu_gate_regs #(
  parameter int DW = 64,
  parameter int NREG = 9,
  parameter int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wen,
  input  logic [IW-1:0]             widx,
  input  logic [DW-1:0]             wval,
  output logic [NREG-1:0][DW-1:0]   q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          sel;
    logic [DW-1:0] d;
    logic [DW-1:0] r;

    always_comb begin
      sel = wen && (widx == IW'(g));
      d   = r;
      if (sel) d = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r <= '0;
      else if (sel) r <= d;
    end

    assign q[g] = r;
  end
endmodule

// File: rtl/pmu_user_gate.sv
module pmu_user_gate
  import pmu_gate_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 10,
  parameter logic [AW-1:0] PRIV_BASE = 10'h310,
  parameter logic [AW-1:0] UREMAP = 10'h010,
  parameter int FRZ_BIT = 31,
  parameter int AEN_BIT = 26,
  parameter int APND_BIT = 7,
  parameter int MODE_LSB = 10,
  parameter logic [DW-1:0] FRZ_UMASK = 'h3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_user,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          exc_valid,
  output logic          exc_cause
);
  localparam int IW = $clog2(NREG);
  localparam logic [DW-1:0] CTL0_UMASK =
    (DW'(1) << FRZ_BIT) | (DW'(1) << AEN_BIT) | (DW'(1) << APND_BIT);

  logic                    hit;
  logic [IW-1:0]           idx;
  logic                    grant;
  logic                    deny;
  cause_e                  cause;
  logic [1:0]              mode;
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [DW-1:0]           cur;
  logic [DW-1:0]           umask;
  logic [DW-1:0]           sel_mask;
  logic [DW-1:0]           merged;
  logic                    wen;

  logic          rsp_valid_d, exc_valid_d, exc_cause_d;
  logic [DW-1:0] rsp_rdata_d;
  logic          rsp_valid_q, exc_valid_q, exc_cause_q;
  logic [DW-1:0] rsp_rdata_q;

  pmu_gate_addr_map #(
    .AW(AW), .PRIV_BASE(PRIV_BASE), .UREMAP(UREMAP), .NREG(NREG), .IW(IW)
  ) u_map (
    .user(req_user), .addr(req_addr), .hit(hit), .idx(idx)
  );

  pmu_gate_perm #(.IW(IW)) u_perm (
    .valid(req_valid), .write(req_write), .user(req_user), .hit(hit),
    .idx(idx), .mode(mode), .grant(grant), .deny(deny), .cause(cause)
  );

  pmu_gate_regs #(.DW(DW), .NREG(NREG), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(wen), .widx(idx), .wval(merged), .q(regs_q)
  );

  assign mode = regs_q[IDX_CTL0][MODE_LSB+1:MODE_LSB];

  always_comb begin
    cur   = regs_q[idx];
    umask = '1;
    if (idx == IW'(IDX_CTL0)) umask = CTL0_UMASK;
    if (idx == IW'(IDX_FRZ))  umask = FRZ_UMASK;
    sel_mask = req_user ? umask : '1;
    merged   = (cur & ~sel_mask) | (req_wdata & sel_mask);
    wen      = req_valid && req_write && grant;
  end

  always_comb begin
    rsp_valid_d = req_valid;
    exc_valid_d = req_valid && deny;
    exc_cause_d = deny ? cause : 1'b0;
    rsp_rdata_d = (req_valid && !req_write && grant) ? (cur & sel_mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      exc_valid_q <= 1'b0;
      exc_cause_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      exc_valid_q <= exc_valid_d;
      exc_cause_q <= exc_cause_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign exc_valid = exc_valid_q;
  assign exc_cause = exc_cause_q;
  assign rsp_rdata = rsp_rdata_q;

  a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_idle_response: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !exc_valid));
  a_r4_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (rsp_valid && rsp_rdata == '0));
  a_r4_refused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && deny) |=> $stable(regs_q));
  a_r4_emu_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && req_write && hit && mode == UMODE_READ)
    |=> (exc_valid && exc_cause == CAUSE_EMU));
  a_r2_priv_no_exc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user) |=> !exc_valid);
  a_r5_upper_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && hit && mode == UMODE_FOUR &&
     (idx == IW'(IDX_CNT5) || idx == IW'(IDX_CNT6)))
    |=> (exc_valid && exc_cause == CAUSE_FAC));
  a_r7_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && req_write) |=> $stable(mode));
  a_r6_ctl0_view: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && !req_write && hit && idx == IW'(IDX_CTL0))
    |=> ((rsp_rdata & ~CTL0_UMASK) == '0));
endmodule

// File: tb/pmu_user_gate_test.sv
module pmu_user_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        exc_valid;
  logic        exc_cause;

  localparam logic [63:0] M_CTL0 = 64'h0000_0000_8400_0080;
  localparam logic [63:0] M_FRZ  = 64'h0000_0000_0000_003F;

  typedef struct {
    logic [63:0] rd;
    logic        exc;
    logic        cause;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] model [9];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  pmu_user_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_user(req_user), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .exc_valid(exc_valid), .exc_cause(exc_cause)
  );

  always #2.5 clk = ~clk;

  task automatic access(input bit wr, input bit usr, input logic [9:0] a,
                        input logic [63:0] wd, input string tag);
    logic [9:0]  eff;
    logic [9:0]  off;
    bit          hit;
    logic [1:0]  md;
    logic [63:0] mk;
    exp_t        e;
    bit          ok;
    bit          dn;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_user = usr; req_addr = a; req_wdata = wd;
    eff = usr ? a + 10'h010 : a;
    off = eff - 10'h310;
    hit = off < 10'd9;
    md  = model[0][11:10];
    e.rd = '0; e.exc = 1'b0; e.cause = 1'b0; e.tag = tag;
    ok = 1'b0; dn = 1'b0;
    if (hit) begin
      if (!usr) ok = 1'b1;
      else if (md == 2'b11 && (off == 7 || off == 8)) dn = 1'b1;
      else if (!wr) begin
        if (md == 2'b01) dn = 1'b1; else ok = 1'b1;
      end else if (md[1]) ok = 1'b1;
      else begin dn = 1'b1; e.cause = (md == 2'b00); end
    end
    mk = '1;
    if (usr && hit && off == 0) mk = M_CTL0;
    if (usr && hit && off == 1) mk = M_FRZ;
    e.exc = dn;
    if (ok && !wr) e.rd = model[off] & mk;
    if (ok && wr)  model[off] = (model[off] & ~mk) | (wd & mk);
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic set_mode(input logic [1:0] md);
    access(1'b1, 1'b0, 10'h310, (model[0] & ~64'hC00) | (64'(md) << 10), "R2 mode set");
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected response rdata=%h exc=%0d expected none", rsp_rdata, exc_valid);
        end else begin
          exp_t e;
          e = sb.pop_front();
          checks++;
          if (rsp_rdata !== e.rd || exc_valid !== e.exc || (e.exc && exc_cause !== e.cause)) begin
            errors++;
            $display("FAIL %s actual rdata=%h exc=%0d cause=%0d expected rdata=%h exc=%0d cause=%0d",
                     e.tag, rsp_rdata, exc_valid, exc_cause, e.rd, e.exc, e.cause);
          end
        end
      end else if (exc_valid) begin
        checks++; errors++;
        $display("FAIL R9 exception without response actual exc=1 expected 0");
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R9 watchdog expired actual cycles=%0d expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || exc_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs in reset actual rsp=%0d exc=%0d expected 0 0", rsp_valid, exc_valid);
    end
    rst_n = 1'b1;
    idle(1);
    // R1: reset contents and mode 00 behaviour
    for (int i = 0; i < 9; i++) access(1'b0, 1'b0, 10'h310 + 10'(i), '0, "R1 reset value");
    access(1'b0, 1'b1, 10'h300, '0, "R1 user read after reset");
    access(1'b1, 1'b1, 10'h300, '1, "R1 user write after reset");
    idle(2);
    // R2: privileged full-width load and read back
    access(1'b1, 1'b0, 10'h310, 64'hFFFF_FFFF_FFFF_F3FF, "R2 write ctl0");
    access(1'b1, 1'b0, 10'h311, 64'hA5A5_A5A5_A5A5_A5A5, "R2 write freeze");
    access(1'b1, 1'b0, 10'h312, 64'h0123_4567_89AB_CDEF, "R2 write aux");
    for (int n = 1; n <= 6; n++)
      access(1'b1, 1'b0, 10'h312 + 10'(n), 64'h1111_1111_1111_1111 * 64'(n), "R2 write counter");
    for (int i = 0; i < 9; i++) access(1'b0, 1'b0, 10'h310 + 10'(i), '0, "R2 full read");
    // Mode 00: reads allowed, writes emulation assist
    access(1'b0, 1'b1, 10'h300, '0, "R6 ctl0 user view");
    access(1'b0, 1'b1, 10'h301, '0, "R6 freeze user view");
    access(1'b0, 1'b1, 10'h303, '0, "R8 user counter1 number");
    access(1'b0, 1'b1, 10'h308, '0, "R3 read counter6 mode00");
    access(1'b1, 1'b1, 10'h304, 64'hDEAD, "R4 write mode00 emu");
    access(1'b0, 1'b0, 10'h314, '0, "R4 state kept after emu");
    // Mode 01
    set_mode(2'b01);
    access(1'b0, 1'b1, 10'h302, '0, "R3 read mode01 fac");
    access(1'b1, 1'b1, 10'h302, 64'hBEEF, "R4 write mode01 fac");
    access(1'b0, 1'b1, 10'h307, '0, "R3 counter5 mode01 fac");
    access(1'b0, 1'b0, 10'h312, '0, "R4 aux kept after fac");
    idle(3);
    // Mode 10: merge writes
    set_mode(2'b10);
    access(1'b1, 1'b1, 10'h300, 64'h0, "R7 clear ctl0 user bits");
    access(1'b0, 1'b0, 10'h310, '0, "R7 ctl0 merge result");
    access(1'b1, 1'b1, 10'h300, '1, "R7 set ctl0 user bits");
    access(1'b0, 1'b0, 10'h310, '0, "R7 ctl0 mode unchanged");
    access(1'b1, 1'b1, 10'h301, 64'h0, "R7 freeze user clear");
    access(1'b0, 1'b0, 10'h311, '0, "R7 freeze merge result");
    access(1'b1, 1'b1, 10'h304, 64'h0F0F_0000_1234_5678, "R7 counter2 full write");
    access(1'b0, 1'b0, 10'h314, '0, "R7 counter2 read back");
    access(1'b0, 1'b1, 10'h307, '0, "R3 counter5 mode10");
    // Mode 11: counters 5 and 6 dropped
    set_mode(2'b11);
    access(1'b0, 1'b1, 10'h307, '0, "R5 read counter5");
    access(1'b1, 1'b1, 10'h308, 64'h77, "R5 write counter6");
    access(1'b0, 1'b0, 10'h318, '0, "R5 counter6 kept");
    access(1'b0, 1'b1, 10'h306, '0, "R5 counter4 still visible");
    access(1'b1, 1'b1, 10'h306, 64'h55, "R5 counter4 still writable");
    access(1'b0, 1'b0, 10'h316, '0, "R5 counter4 read back");
    access(1'b0, 1'b0, 10'h317, '0, "R5 priv counter5 mode11");
    // R8: unmapped numbers
    access(1'b0, 1'b1, 10'h310, '0, "R8 user unmapped high");
    access(1'b1, 1'b1, 10'h309, '1, "R8 user unmapped write");
    access(1'b0, 1'b0, 10'h300, '0, "R8 priv user number");
    access(1'b0, 1'b0, 10'h319, '0, "R8 priv past end");
    access(1'b0, 1'b0, 10'h30F, '0, "R8 priv below base");
    for (int i = 0; i < 9; i++) access(1'b0, 1'b0, 10'h310 + 10'(i), '0, "R8 state after unmapped");
    idle(4);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9 missing responses actual=%0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule